// File: doc/BRIEF.md
# Power-Management Command Port SMI Generator

This block sits behind the byte-wide power-management command port of a chipset's power-management function. Every byte written to the port is classified in the write cycle. One reserved code turns ACPI mode on and another turns it off, by setting or clearing the SCI-enable bit of the power-management control register. Every other code is a request for system management mode. Such a request produces a one-cycle SMI pulse only when the SMI-enable bit of a local configuration byte is set.

The configuration byte is written through its own strobe and can be read back. At reset it is cleared, unless the SMM-disable strap is asserted. In that case it comes out of reset with only the SMI-enable bit set. The last byte written to the command port is also held and can be read back. Consecutive writes are judged one by one, so a burst of qualifying writes produces one pulse per write.

Top module: `apm_smi_gen`

## Requirements
- R1: A write of 0xF1 on `apm_data` with `apm_wr` high sets `sci_en` at the next rising clock edge.
- R2: A write of 0xF0 clears `sci_en` at the next rising clock edge.
- R3: A write of 0xF0 or 0xF1 never raises `smi_pulse`, whatever the configuration byte holds.
- R4: A write of any other code raises `smi_pulse` for the cycle after the write when bit 1 of the configuration byte is set, and leaves it low when that bit is clear.
- R5: `smi_pulse` is high only in a cycle that follows a qualifying write. Back-to-back qualifying writes each give their own high cycle, so the pulse stays high once per write.
- R6: `apm_last` holds the byte of the most recent command-port write, updated at the edge of that write.
- R7: While `rst_n` is low, `sci_en`, `smi_pulse` and `apm_last` are 0. `cfg_byte` is 0x00 when `smm_off_strap` is low and 0x02 when it is high.
- R8: A `cfg_wr` pulse loads `cfg_wdata` into `cfg_byte` at the next edge. A command write in the same cycle is judged against the configuration value held before that edge.
- R9: Writes of codes other than 0xF0 and 0xF1, and cycles without a write, leave `sci_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smm_off_strap | input | 1 | Strap that disables SMM; chooses the reset value of the configuration byte |
| apm_wr | input | 1 | Command-port write strobe |
| apm_data | input | 8 | Command-port write data |
| cfg_wr | input | 1 | Configuration-byte write strobe |
| cfg_wdata | input | 8 | Configuration-byte write data |
| cfg_byte | output | 8 | Current configuration byte; bit 1 enables SMI |
| sci_en | output | 1 | SCI-enable (ACPI mode) bit |
| smi_pulse | output | 1 | One-cycle SMI request |
| apm_last | output | 8 | Last byte written to the command port |

## Verification
The in-RTL assertions check on every cycle that each mode code drives `sci_en` to its value, that other codes and idle cycles keep it steady, and that mode codes never yield a pulse. They also check that a pulse is always preceded by a write and that `apm_last` captures the written byte. The ordering between a configuration write and a command write in the same cycle, both strap-dependent reset values, and pulse trains from back-to-back writes can only be shown by the bench scenarios, which compare against a behavioural model.

// File: rtl/apm_smi_pkg.sv
package apm_smi_pkg;

   typedef enum logic [1:0] {
      KIND_IDLE     = 2'd0,
      KIND_ACPI_ON  = 2'd1,
      KIND_ACPI_OFF = 2'd2,
      KIND_SMI_REQ  = 2'd3
   } apm_kind_e;

endpackage

// File: rtl/apm_cmd_decode.sv
module apm_cmd_decode
   import apm_smi_pkg::*;
#(
   parameter int unsigned        CMD_W    = 8,
   parameter logic [CMD_W-1:0]   ON_CODE  = 8'hF1,
   parameter logic [CMD_W-1:0]   OFF_CODE = 8'hF0
) (
   input  logic             wr,
   input  logic [CMD_W-1:0] data,
   output apm_kind_e        kind
);

   if (ON_CODE == OFF_CODE) begin : g_bad_codes
      $error("apm_cmd_decode: ON_CODE and OFF_CODE must differ");
   end

   logic hit_on;
   logic hit_off;

   assign hit_on  = (data == ON_CODE);
   assign hit_off = (data == OFF_CODE);

   always_comb begin
      if (!wr)          kind = KIND_IDLE;
      else if (hit_on)  kind = KIND_ACPI_ON;
      else if (hit_off) kind = KIND_ACPI_OFF;
      else              kind = KIND_SMI_REQ;
   end

endmodule

// File: rtl/apm_cfg_reg.sv
module apm_cfg_reg #(
   parameter int unsigned      CFG_W       = 8,
   parameter int unsigned      SMI_EN_BIT  = 1,
   parameter bit               HAS_STRAP   = 1'b1,
   parameter logic [CFG_W-1:0] STRAP_VALUE = 8'h02
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_q,
   output logic             smi_allow
);

   if (SMI_EN_BIT >= CFG_W) begin : g_bad_bit
      $error("apm_cfg_reg: SMI_EN_BIT outside the configuration byte");
   end

   logic [CFG_W-1:0] rst_value;

   if (HAS_STRAP) begin : g_strap
      assign rst_value = strap ? STRAP_VALUE : '0;
   end else begin : g_nostrap
      logic unused_strap;
      assign unused_strap = strap;
      assign rst_value    = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= rst_value;
      else if (cfg_wr) cfg_q <= cfg_wdata;
   end

   assign smi_allow = cfg_q[SMI_EN_BIT];

endmodule

// File: rtl/apm_mode_ctl.sv
module apm_mode_ctl
   import apm_smi_pkg::*;
#(
   parameter int unsigned      CMD_W    = 8,
   parameter logic [CMD_W-1:0] ON_CODE  = 8'hF1,
   parameter logic [CMD_W-1:0] OFF_CODE = 8'hF0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  apm_kind_e        kind,
   input  logic             wr,
   input  logic [CMD_W-1:0] data,
   input  logic             smi_allow,
   output logic             sci_en,
   output logic             smi_pulse,
   output logic [CMD_W-1:0] cmd_last
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sci_en    <= 1'b0;
         smi_pulse <= 1'b0;
         cmd_last  <= '0;
      end else begin
         smi_pulse <= (kind == KIND_SMI_REQ) && smi_allow;
         if (kind == KIND_ACPI_ON)       sci_en <= 1'b1;
         else if (kind == KIND_ACPI_OFF) sci_en <= 1'b0;
         if (wr) cmd_last <= data;
      end
   end

   // checks against raw port inputs, not the decoded kind
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_sci_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && data == ON_CODE) |=> sci_en);

   assert_sci_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && data == OFF_CODE) |=> !sci_en);

   assert_no_smi_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (data == ON_CODE || data == OFF_CODE)) |=> !smi_pulse);

   assert_smi_needs_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && smi_pulse) |-> $past(wr));

   assert_smi_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!smi_allow) |=> !smi_pulse);

   assert_last_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (cmd_last == $past(data)));

   assert_sci_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && (data == ON_CODE || data == OFF_CODE)) |=> $stable(sci_en));

endmodule

// File: rtl/apm_smi_gen.sv
module apm_smi_gen #(
   parameter int unsigned CMD_W      = 8,
   parameter int unsigned CFG_W      = 8,
   parameter int unsigned SMI_EN_BIT = 1,
   parameter bit          HAS_STRAP  = 1'b1,
   parameter logic [CMD_W-1:0] ON_CODE     = 8'hF1,
   parameter logic [CMD_W-1:0] OFF_CODE    = 8'hF0,
   parameter logic [CFG_W-1:0] STRAP_VALUE = 8'h02
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smm_off_strap,
   input  logic             apm_wr,
   input  logic [CMD_W-1:0] apm_data,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_byte,
   output logic             sci_en,
   output logic             smi_pulse,
   output logic [CMD_W-1:0] apm_last
);
   import apm_smi_pkg::*;

   apm_kind_e kind;
   logic      smi_allow;

   apm_cmd_decode #(
      .CMD_W(CMD_W), .ON_CODE(ON_CODE), .OFF_CODE(OFF_CODE)
   ) u_decode (
      .wr(apm_wr), .data(apm_data), .kind(kind)
   );

   apm_cfg_reg #(
      .CFG_W(CFG_W), .SMI_EN_BIT(SMI_EN_BIT),
      .HAS_STRAP(HAS_STRAP), .STRAP_VALUE(STRAP_VALUE)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .strap(smm_off_strap),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_q(cfg_byte), .smi_allow(smi_allow)
   );

   apm_mode_ctl #(
      .CMD_W(CMD_W), .ON_CODE(ON_CODE), .OFF_CODE(OFF_CODE)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .kind(kind), .wr(apm_wr), .data(apm_data),
      .smi_allow(smi_allow), .sci_en(sci_en), .smi_pulse(smi_pulse),
      .cmd_last(apm_last)
   );

endmodule

// File: tb/apm_smi_gen_tb_top.sv
`timescale 1ns/100ps
module apm_smi_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strap = 1'b0;
   logic       apm_wr = 1'b0;
   logic [7:0] apm_data = 8'h00;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_byte;
   logic       sci_en;
   logic       smi_pulse;
   logic [7:0] apm_last;

   int checks = 0;
   int errors = 0;

   // reference model state
   bit       m_sci;
   bit       m_smi;
   bit [7:0] m_last;
   bit [7:0] m_cfg;

   always #2.5 clk = ~clk;

   apm_smi_gen dut_i (
      .clk(clk), .rst_n(rst_n), .smm_off_strap(strap),
      .apm_wr(apm_wr), .apm_data(apm_data),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_byte(cfg_byte), .sci_en(sci_en),
      .smi_pulse(smi_pulse), .apm_last(apm_last)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(sci_en === m_sci, "R1 R2 R9 sci_en", sci_en, m_sci);
      chk(smi_pulse === m_smi, "R3 R4 R5 smi_pulse", smi_pulse, m_smi);
      chk(apm_last === m_last, "R6 apm_last", apm_last, m_last);
      chk(cfg_byte === m_cfg, "R8 cfg_byte", cfg_byte, m_cfg);
   endtask

   // drive at negedge, model updates at the edge, compare at next negedge
   task automatic step(input bit wr, input bit [7:0] d, input bit cw, input bit [7:0] cd);
      apm_wr = wr; apm_data = d; cfg_wr = cw; cfg_wdata = cd;
      @(posedge clk);
      m_smi = wr && d != 8'hF1 && d != 8'hF0 && m_cfg[1];
      if (wr && d == 8'hF1) m_sci = 1'b1;
      if (wr && d == 8'hF0) m_sci = 1'b0;
      if (wr) m_last = d;
      if (cw) m_cfg = cd;
      @(negedge clk);
      apm_wr = 1'b0; cfg_wr = 1'b0;
      compare_all();
   endtask

   task automatic do_reset(input bit s);
      @(negedge clk);
      rst_n = 1'b0; strap = s; apm_wr = 1'b0; cfg_wr = 1'b0;
      #1;
      m_sci = 0; m_smi = 0; m_last = 0; m_cfg = s ? 8'h02 : 8'h00;
      // R7: values held while reset is asserted
      chk(sci_en === 1'b0, "R7 sci_en in reset", sci_en, 0);
      chk(smi_pulse === 1'b0, "R7 smi_pulse in reset", smi_pulse, 0);
      chk(apm_last === 8'h00, "R7 apm_last in reset", apm_last, 0);
      chk(cfg_byte === m_cfg, "R7 cfg_byte in reset", cfg_byte, m_cfg);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();
   endtask

   initial begin : watchdog
      #(5ns * 100000);
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      do_reset(1'b0);
      step(1, 8'h12, 0, 8'h00);   // R4: other code, enable bit clear -> no pulse
      step(1, 8'hF1, 0, 8'h00);   // R1
      step(0, 8'h00, 1, 8'h02);   // R8: enable SMI
      step(1, 8'h55, 0, 8'h00);   // R4: pulse
      step(1, 8'h01, 0, 8'h00);   // R5 back-to-back
      step(1, 8'h02, 0, 8'h00);   // R5
      step(1, 8'hF0, 0, 8'h00);   // R2, R3
      step(1, 8'h03, 0, 8'h00);   // R5
      step(1, 8'hF1, 0, 8'h00);   // R3 with enable set
      step(1, 8'h77, 1, 8'h00);   // R8: old cfg value gates -> pulse
      step(1, 8'h78, 0, 8'h00);   // R4: now disabled
      step(1, 8'h79, 1, 8'hFD);   // R8: bit1 still 0 before edge
      step(1, 8'h7A, 0, 8'h00);   // R4: 0xFD has bit1 clear
      step(0, 8'hAA, 0, 8'h00);   // R9: idle keeps sci_en
      do_reset(1'b1);             // R7 strap variant
      step(1, 8'h10, 0, 8'h00);   // R4: strap value enables SMI
      step(1, 8'hF1, 0, 8'h00);
      step(1, 8'h11, 0, 8'h00);   // R9: sci_en unchanged by other code
      for (int i = 0; i < 400; i++) begin
         bit [7:0] d;
         int sel;
         sel = $urandom_range(0, 7);
         d = (sel == 0) ? 8'hF1 : (sel == 1) ? 8'hF0 : 8'($urandom);
         step(1'($urandom_range(0, 3) != 0), d,
              1'($urandom_range(0, 5) == 0), 8'($urandom));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule